// File: doc/BRIEF.md
# PHY Management Register Block with Built-in PHY Model

This block gives a host a small set of 32-bit registers through which it issues management reads and writes to a PHY. Instead of driving a serial management line, the block answers the commands from a built-in model of a 32-register PHY that responds at a single PHY address, set by a parameter. The host writes the data it wants to send into a write-data register. It then writes a command word that holds the PHY address, the register address, the operation code and an initiate flag. The command finishes on the clock edge that accepts it, so a read result appears in the read-data register on the next cycle.

Several PHY registers are not stored. Their values are computed when they are read, from the advertisement register and from a link-up input. These are the basic status register, the link-partner ability register, the extended speed register and a diagnostic register. Every PHY write also forces the self-reset bit and the restart-negotiation bit of the PHY control register to zero. Two one-cycle flags report an unsupported operation code and an interface enable given with a zero clock divider.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: Host word addresses are 0 for the enable register, 1 for the command, 2 for write data and 3 for read data. In the command word, bits 28:24 are the PHY address, 20:16 the register address, 15:14 the operation code and bit 11 the initiate flag. Operation code 1 with initiate set writes bits 15:0 of the write-data register into the addressed PHY register.
- R2: Operation code 2 with initiate set loads the read-data register with the PHY register value, zero-extended. The value can be read on the next cycle, and it keeps that value until the next read command.
- R3: A command with initiate set and operation code 0 or 3 changes no state. `bad_op_o` is high for the one cycle that follows it.
- R4: When the PHY address in the command differs from parameter PHY_ADDR (default 7), a read returns 0x0000FFFF and a write changes nothing.
- R5: Reading the command register returns the last value written to it, with bit 7 always set.
- R6: The enable register keeps only bits 6:0 of a write. Bit 6 is the enable and bits 5:0 are the divider. Writing it with bit 6 set and bits 5:0 zero raises `cfg_err_o` for one cycle.
- R7: After reset, PHY register 0 is 0x3100, register 2 is 0x0300, register 3 is 0xE400 and register 4 is 0x01E1.
- R8: PHY register 1 reads 0x782E while `link_up_i` is high and 0x0000 while it is low.
- R9: PHY register 5 reads 0x4001 OR'd with bits 8:5 of register 4.
- R10: PHY register 17 reads 0x8000. While the link is up, register 18 reads bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with all other bits zero. While the link is down it reads 0.
- R11: After any PHY write, bits 15 and 9 of PHY register 0 are zero, including when register 0 itself was the one written.
- R12: A command written with initiate clear performs no PHY access and leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link condition seen by the PHY model |
| bus_we_i | input | 1 | Host write strobe |
| bus_addr_i | input | ADDR_W | Host word address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data (combinational) |
| bad_op_o | output | 1 | Pulse: initiate given with an unsupported operation code |
| cfg_err_o | output | 1 | Pulse: interface enabled with a zero divider |

## Verification
The hardest situation to reach is a write to PHY register 0 with the self-reset and restart bits set. The write must store every other bit while those two are cleared in the same cycle. The bench reaches it by writing 0xFFFF and then 0x8200 to register 0, and after each write it reads the register back through a read command. The computed registers are another case that is hard to cover. The bench rewrites the advertisement register with several single-mode patterns and toggles the link input, then reads registers 5, 17 and 18 after each change. A write to a foreign PHY address is checked by reading the same register at the real address afterwards.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_DW       = 16;
  localparam int NUM_PHY_REGS = 32;
  localparam int RA_W         = $clog2(NUM_PHY_REGS);

  localparam int HA_CTRL  = 0;
  localparam int HA_CMD   = 1;
  localparam int HA_WDATA = 2;
  localparam int HA_RDATA = 3;

  localparam logic [REG_DW-1:0] STAT_LINK_VAL = 16'h782E;
  localparam logic [REG_DW-1:0] LP_BASE_VAL   = 16'h4001;
  localparam logic [REG_DW-1:0] LP_COPY_MASK  = 16'h01E0;
  localparam logic [REG_DW-1:0] EXT_SPD_VAL   = 16'h8000;
  localparam logic [REG_DW-1:0] CTL_SELFCLR   = 16'h8200;
  localparam logic [REG_DW-1:0] NO_DEV_VAL    = 16'hFFFF;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSV  = 2'd3
  } mdio_op_e;

  typedef struct packed {
    logic [4:0]      phy;
    logic [RA_W-1:0] ra;
    mdio_op_e        op;
    logic            go;
  } mdio_cmd_t;

  function automatic logic [REG_DW-1:0] phy_rst_val(int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic                 valid_i,
  input  logic [31:0]          word_i,
  output logic [RA_W-1:0]      ra_o,
  output logic                 do_wr_o,
  output logic                 do_rd_o,
  output logic                 hit_o,
  output logic                 bad_o
);
  mdio_cmd_t cmd;
  logic      unused_bits;

  assign cmd.phy = word_i[28:24];
  assign cmd.ra  = word_i[16 +: RA_W];
  assign cmd.op  = mdio_op_e'(word_i[15:14]);
  assign cmd.go  = word_i[11];
  assign unused_bits = ^{word_i[31:29], word_i[23:21], word_i[13:12], word_i[10:0]};

  assign ra_o    = cmd.ra;
  assign hit_o   = (cmd.phy == 5'(PHY_ADDR));
  assign do_wr_o = valid_i && cmd.go && (cmd.op == OP_WR);
  assign do_rd_o = valid_i && cmd.go && (cmd.op == OP_RD);
  assign bad_o   = valid_i && cmd.go && (cmd.op == OP_NONE || cmd.op == OP_RSV);
endmodule

// File: rtl/phy_mgmt_phy.sv
module phy_mgmt_phy
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_i,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  output logic [REG_DW-1:0] rd_data_o
);
  logic [REG_DW-1:0] regs_q [NUM_PHY_REGS];
  logic [REG_DW-1:0] adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHY_REGS; i++) regs_q[i] <= phy_rst_val(i);
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_PHY_REGS; i++) begin
        if (i == 0)
          regs_q[i] <= ((addr_i == RA_W'(i)) ? wr_data_i : regs_q[i]) & ~CTL_SELFCLR;
        else if (addr_i == RA_W'(i))
          regs_q[i] <= wr_data_i;
      end
    end
  end

  assign adv = regs_q[4];

  // synthetic registers computed from advertisement and link
  always_comb begin
    case (int'(addr_i))
      1:  rd_data_o = link_i ? STAT_LINK_VAL : '0;
      5:  rd_data_o = LP_BASE_VAL | (adv & LP_COPY_MASK);
      17: rd_data_o = EXT_SPD_VAL;
      18: begin
        rd_data_o = '0;
        if (link_i) begin
          rd_data_o[10] = adv[7] | adv[8];
          rd_data_o[11] = adv[8] | adv[6];
        end
      end
      default: rd_data_o = regs_q[addr_i];
    endcase
  end
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PHY_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bad_op_o,
  output logic              cfg_err_o
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] ctrl_q;
  logic [31:0]       cmd_q;
  logic [REG_DW-1:0] wdata_q;
  logic [REG_DW-1:0] rdata_q;
  logic              bad_op_q, cfg_err_q;

  logic              wr_ctrl, wr_cmd, wr_wdata;
  logic [RA_W-1:0]   phy_ra;
  logic              do_wr, do_rd, hit, bad;
  logic [REG_DW-1:0] phy_rd;

  assign wr_ctrl  = bus_we_i && (bus_addr_i == ADDR_W'(HA_CTRL));
  assign wr_cmd   = bus_we_i && (bus_addr_i == ADDR_W'(HA_CMD));
  assign wr_wdata = bus_we_i && (bus_addr_i == ADDR_W'(HA_WDATA));

  phy_mgmt_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .valid_i (wr_cmd),
    .word_i  (bus_wdata_i),
    .ra_o    (phy_ra),
    .do_wr_o (do_wr),
    .do_rd_o (do_rd),
    .hit_o   (hit),
    .bad_o   (bad)
  );

  phy_mgmt_phy u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_i    (link_up_i),
    .wr_en_i   (do_wr && hit),
    .addr_i    (phy_ra),
    .wr_data_i (wdata_q),
    .rd_data_o (phy_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      cmd_q     <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      bad_op_q  <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      bad_op_q  <= bad;
      cfg_err_q <= wr_ctrl && bus_wdata_i[6] && (bus_wdata_i[5:0] == '0);
      if (wr_ctrl)  ctrl_q  <= bus_wdata_i[CTRL_W-1:0];
      if (wr_cmd)   cmd_q   <= bus_wdata_i;
      if (wr_wdata) wdata_q <= bus_wdata_i[REG_DW-1:0];
      if (do_rd)    rdata_q <= hit ? phy_rd : NO_DEV_VAL;
    end
  end

  always_comb begin
    case (int'(bus_addr_i))
      HA_CTRL:  bus_rdata_o = 32'(ctrl_q);
      HA_CMD:   bus_rdata_o = cmd_q | 32'h80;
      HA_WDATA: bus_rdata_o = 32'(wdata_q);
      HA_RDATA: bus_rdata_o = 32'(rdata_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  assign bad_op_o  = bad_op_q;
  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              bad_op_o,
  input logic              cfg_err_o,
  input logic [15:0]       rdata_q
);
  // R3
  bad_op_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |-> $past(bus_we_i && bus_addr_i == ADDR_W'(1) && bus_wdata_i[11]
                       && bus_wdata_i[15:14] != 2'd1 && bus_wdata_i[15:14] != 2'd2));

  // R6
  cfg_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(bus_we_i && bus_addr_i == ADDR_W'(0) && bus_wdata_i[6]
                        && bus_wdata_i[5:0] == 6'd0));

  // R6
  ctrl_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(0)) |-> (bus_rdata_o[31:7] == '0));

  // R5
  cmd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(1)) |-> bus_rdata_o[7]);

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_we_i && bus_addr_i == ADDR_W'(1) && bus_wdata_i[11]
           && bus_wdata_i[15:14] == 2'd2) |-> $stable(rdata_q));
endmodule

bind phy_mgmt_ctrl phy_mgmt_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_phy_mgmt_ctrl.sv
module tb_phy_mgmt_ctrl;
  localparam int ADDR_W = 4;
  localparam int PA     = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              link_up_i = 1'b1;
  logic              bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              bad_op_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  logic last_bad, last_cfg;

  phy_mgmt_ctrl #(.ADDR_W(ADDR_W), .PHY_ADDR(PA)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = ADDR_W'(a); bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    last_bad = bad_op_o;
    last_cfg = cfg_err_o;
  endtask

  task automatic host_read(int a, output logic [31:0] d);
    bus_addr_i = ADDR_W'(a);
    #1;
    d = bus_rdata_o;
  endtask

  function automatic logic [31:0] cmd(int pa, int ra, int op, bit go);
    return (32'(pa) << 24) | (32'(ra) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic phy_wr(int pa, int ra, logic [15:0] d);
    host_write(2, 32'(d));
    host_write(1, cmd(pa, ra, 1, 1'b1));
  endtask

  task automatic phy_rd(int pa, int ra, output logic [31:0] d);
    host_write(1, cmd(pa, ra, 2, 1'b1));
    host_read(3, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    host_read(0, v); check("R6 reset ctrl", v, 32'h0);
    host_read(1, v); check("R5 reset cmd", v, 32'h80);
    host_read(3, v); check("R2 reset rdata", v, 32'h0);
    check("R3 reset flag", {30'd0, bad_op_o, cfg_err_o}, 32'h0);
  endtask

  task automatic t_reset_vals;
    logic [31:0] v;
    phy_rd(PA, 0, v); check("R7 reg0", v, 32'h3100);
    phy_rd(PA, 2, v); check("R7 reg2", v, 32'h0300);
    phy_rd(PA, 3, v); check("R7 reg3", v, 32'hE400);
    phy_rd(PA, 4, v); check("R7 reg4", v, 32'h01E1);
  endtask

  task automatic t_status;
    logic [31:0] v;
    link_up_i = 1'b1;
    phy_rd(PA, 1, v); check("R8 link up", v, 32'h782E);
    link_up_i = 1'b0;
    phy_rd(PA, 1, v); check("R8 link down", v, 32'h0);
    phy_rd(PA, 18, v); check("R10 reg18 link down", v, 32'h0);
    link_up_i = 1'b1;
  endtask

  task automatic t_computed;
    logic [31:0] v;
    phy_rd(PA, 5, v);  check("R9 reg5 default adv", v, 32'h41E1);
    phy_rd(PA, 17, v); check("R10 reg17", v, 32'h8000);
    phy_rd(PA, 18, v); check("R10 reg18 default adv", v, 32'h0C00);
    phy_wr(PA, 4, 16'h0041);
    phy_rd(PA, 5, v);  check("R9 reg5 10full", v, 32'h4041);
    phy_rd(PA, 18, v); check("R10 reg18 10full", v, 32'h0800);
    phy_wr(PA, 4, 16'h0081);
    phy_rd(PA, 18, v); check("R10 reg18 100half", v, 32'h0400);
    phy_wr(PA, 4, 16'h0101);
    phy_rd(PA, 18, v); check("R10 reg18 100full", v, 32'h0C00);
    phy_wr(PA, 4, 16'h0021);
    phy_rd(PA, 18, v); check("R10 reg18 10half", v, 32'h0);
    phy_rd(PA, 5, v);  check("R9 reg5 10half", v, 32'h4021);
  endtask

  task automatic t_write;
    logic [31:0] v;
    phy_wr(PA, 9, 16'h1234);
    phy_rd(PA, 9, v); check("R1 write reg9", v, 32'h1234);
    phy_rd(PA, 0, v); check("R11 reg0 after other write", v, 32'h3100);
    phy_wr(PA, 0, 16'hFFFF);
    phy_rd(PA, 0, v); check("R11 reg0 write all ones", v, 32'h7DFF);
    phy_wr(PA, 0, 16'h8200);
    phy_rd(PA, 0, v); check("R11 reg0 self clear", v, 32'h0);
  endtask

  task automatic t_nodev;
    logic [31:0] v;
    phy_rd(3, 9, v); check("R4 read absent phy", v, 32'h0000FFFF);
    phy_wr(3, 9, 16'hAAAA);
    phy_rd(PA, 9, v); check("R4 write absent phy ignored", v, 32'h1234);
  endtask

  task automatic t_badop;
    logic [31:0] v;
    phy_rd(PA, 17, v);
    host_write(1, cmd(PA, 2, 0, 1'b1));
    check("R3 op0 flag", 32'(last_bad), 32'h1);
    host_read(3, v); check("R3 op0 rdata kept", v, 32'h8000);
    host_write(2, 32'h5555);
    host_write(1, cmd(PA, 9, 3, 1'b1));
    check("R3 op3 flag", 32'(last_bad), 32'h1);
    phy_rd(PA, 9, v); check("R3 op3 no write", v, 32'h1234);
    check("R3 valid op no flag", 32'(last_bad), 32'h0);
  endtask

  task automatic t_noinit;
    logic [31:0] v;
    phy_rd(PA, 17, v);
    host_write(1, cmd(PA, 2, 2, 1'b0));
    host_read(3, v); check("R12 read without initiate", v, 32'h8000);
    host_write(2, 32'h7777);
    host_write(1, cmd(PA, 9, 1, 1'b0));
    phy_rd(PA, 9, v); check("R12 write without initiate", v, 32'h1234);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    host_write(1, 32'h12345678);
    check("R3 no initiate no flag", 32'(last_bad), 32'h0);
    host_read(1, v); check("R5 cmd readback", v, 32'h123456F8);
    host_write(0, 32'hFFFFFF40);
    check("R6 zero divider flag", 32'(last_cfg), 32'h1);
    host_read(0, v); check("R6 ctrl keeps 7 bits", v, 32'h40);
    host_write(0, 32'h45);
    check("R6 nonzero divider no flag", 32'(last_cfg), 32'h0);
    host_read(0, v); check("R6 ctrl value", v, 32'h45);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reset_vals();
    t_status();
    t_computed();
    t_write();
    t_nodev();
    t_badop();
    t_noinit();
    t_regs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule